// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is a small counter driven by one external input pin. It has two modes, chosen by a single control bit. In event mode it counts the active transitions of the pin. In gated mode it counts ticks of a slow internal time base, but only while the pin holds the active level. The same polarity bit sets the active transition in event mode and the active level in gated mode. The pin is asynchronous and passes through a flop synchronizer before any edge or level is examined. The time base arrives as a one-cycle strobe from a divider chain outside the block.

The counter can be loaded at any time through a write strobe. It wraps past its all-ones value. Two sticky flags, each with its own interrupt enable, report a counter wrap and a qualifying pin transition. Software clears each flag with a one-cycle clear pulse. A master enable freezes counting and flag setting, but the counter can still be written while it is frozen.

Top module: `pulse_acc_top`

## Requirements
- R1: While reset is asserted and after it is released, the counter reads 0x00, both flags read 0 and both interrupt outputs read 0.
- R2: With `cfg_gated`=0, the counter increments once for each active pin transition. With `cfg_pol`=1 the active transition is a rise (0 to 1). With `cfg_pol`=0 it is a fall (1 to 0). The other transition has no effect on the count.
- R3: With `cfg_gated`=1, the counter increments in every cycle where `slow_tick`=1 and the synchronized pin equals `cfg_pol`. In a cycle without a tick, the counter does not change.
- R4: An increment from 0xFF gives 0x00 and sets `ovf_flag` in the same clock edge. No other event sets `ovf_flag`.
- R5: With `cfg_en`=0, the pin and `slow_tick` have no effect. The counter holds its value and neither flag is set.
- R6: When `cnt_wr`=1, the counter takes `cnt_wdata` at the next edge. A write takes priority over a concurrent increment.
- R7: `edge_flag` is set by the active transition in event mode. In gated mode it is set by the trailing transition of the gate: a fall when `cfg_pol`=1, a rise when `cfg_pol`=0.
- R8: Each flag stays set until its clear input is pulsed. If a set and a clear fall in the same cycle, the set wins.
- R9: `ovf_irq` equals `ovf_flag` AND `ovf_ie`. `edge_irq` equals `edge_flag` AND `edge_ie`.
- R10: The pin passes through two synchronizer flops. A pin change driven before clock edge k is counted at edge k+2, so the counter value changes after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pin_in | input | 1 | Asynchronous external input |
| slow_tick | input | 1 | One-cycle strobe of the gated-mode time base |
| cfg_en | input | 1 | Master enable for counting and flag setting |
| cfg_gated | input | 1 | 0 = event counting, 1 = gated time accumulation |
| cfg_pol | input | 1 | 1 = rise / high level active, 0 = fall / low level active |
| cnt_wr | input | 1 | Counter load strobe |
| cnt_wdata | input | 8 | Counter load value |
| ovf_clr | input | 1 | Clear pulse for the overflow flag |
| edge_clr | input | 1 | Clear pulse for the edge flag |
| ovf_ie | input | 1 | Overflow interrupt enable |
| edge_ie | input | 1 | Edge interrupt enable |
| cnt_q | output | 8 | Current counter value |
| ovf_flag | output | 1 | Sticky wrap flag |
| edge_flag | output | 1 | Sticky pin-transition flag |
| ovf_irq | output | 1 | Overflow interrupt request |
| edge_irq | output | 1 | Edge interrupt request |

## Verification
The hardest cases to reach are those where two actions meet in the same clock edge: a wrap whose flag set coincides with a clear pulse, and a load strobe that coincides with a qualified increment. Both depend on the pin's synchronizer latency. The stimulus first settles the synchronized pin level and then writes the counter to 0xFF or a marker value. It then raises `slow_tick` in gated mode together with the clear or write, which makes the coincidence land on a known edge. A long random phase then mixes mode and polarity changes, loads and clears. A behavioural model compares against the design on every cycle.

// File: rtl/pa_pkg.sv
package pa_pkg;
   typedef enum logic {
      PA_MODE_EVENT = 1'b0,
      PA_MODE_GATED = 1'b1
   } pa_mode_e;

   typedef struct packed {
      logic rise;
      logic fall;
      logic level;
   } pa_pin_ev_t;
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d_in,
   output logic q_out
);
   logic [STAGES-1:0] chain_q;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("pa_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               chain_q[gi] <= 1'b0;
            end else if (gi == 0) begin
               chain_q[gi] <= d_in;
            end else begin
               chain_q[gi] <= chain_q[(gi == 0) ? 0 : gi-1];
            end
         end
      end
   endgenerate

   assign q_out = chain_q[STAGES-1];
endmodule

// File: rtl/pa_qualify.sv
module pa_qualify
   import pa_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     pin_sync,
   input  logic     slow_tick,
   input  logic     en,
   input  pa_mode_e mode,
   input  logic     pol,
   output logic     inc,
   output logic     edge_set
);
   logic       pin_prev;
   pa_pin_ev_t ev;
   logic       active_edge;
   logic       trailing_edge;

   always_ff @(posedge clk) begin
      if (!rst_n) pin_prev <= 1'b0;
      else        pin_prev <= pin_sync;
   end

   always_comb begin
      ev.rise  = pin_sync & ~pin_prev;
      ev.fall  = ~pin_sync & pin_prev;
      ev.level = (pin_sync == pol);
      active_edge   = pol ? ev.rise : ev.fall;
      trailing_edge = pol ? ev.fall : ev.rise;
      inc      = 1'b0;
      edge_set = 1'b0;
      if (en) begin
         unique case (mode)
            PA_MODE_EVENT: begin
               inc      = active_edge;
               edge_set = active_edge;
            end
            PA_MODE_GATED: begin
               inc      = slow_tick & ev.level;
               edge_set = trailing_edge;
            end
            default: begin
               inc      = 1'b0;
               edge_set = 1'b0;
            end
         endcase
      end
   end
endmodule

// File: rtl/pa_counter.sv
module pa_counter #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             wr,
   input  logic [CNT_W-1:0] wdata,
   output logic [CNT_W-1:0] cnt,
   output logic             wrap
);
   logic [CNT_W-1:0] cnt_plus;
   logic             carry;

   assign {carry, cnt_plus} = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};
   assign wrap = inc & ~wr & carry;

   always_ff @(posedge clk) begin
      if (!rst_n)   cnt <= '0;
      else if (wr)  cnt <= wdata;
      else if (inc) cnt <= cnt_plus;
   end
endmodule

// File: rtl/pa_flag.sv
module pa_flag (
   input  logic clk,
   input  logic rst_n,
   input  logic set,
   input  logic clr,
   input  logic ie,
   output logic flag,
   output logic irq
);
   always_ff @(posedge clk) begin
      if (!rst_n)   flag <= 1'b0;
      else if (set) flag <= 1'b1;
      else if (clr) flag <= 1'b0;
   end

   assign irq = flag & ie;
endmodule

// File: rtl/pulse_acc_top.sv
module pulse_acc_top
   import pa_pkg::*;
#(
   parameter int CNT_W       = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin_in,
   input  logic             slow_tick,
   input  logic             cfg_en,
   input  logic             cfg_gated,
   input  logic             cfg_pol,
   input  logic             cnt_wr,
   input  logic [CNT_W-1:0] cnt_wdata,
   input  logic             ovf_clr,
   input  logic             edge_clr,
   input  logic             ovf_ie,
   input  logic             edge_ie,
   output logic [CNT_W-1:0] cnt_q,
   output logic             ovf_flag,
   output logic             edge_flag,
   output logic             ovf_irq,
   output logic             edge_irq
);
   generate
      if (CNT_W < 2) begin : g_bad_width
         $error("pulse_acc_top: CNT_W must be at least 2");
      end
   endgenerate

   logic     pin_s;
   logic     inc;
   logic     edge_set;
   logic     wrap;
   pa_mode_e mode;

   assign mode = pa_mode_e'(cfg_gated);

   pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_in  (pin_in),
      .q_out (pin_s)
   );

   pa_qualify u_qual (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_sync  (pin_s),
      .slow_tick (slow_tick),
      .en        (cfg_en),
      .mode      (mode),
      .pol       (cfg_pol),
      .inc       (inc),
      .edge_set  (edge_set)
   );

   pa_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (inc),
      .wr    (cnt_wr),
      .wdata (cnt_wdata),
      .cnt   (cnt_q),
      .wrap  (wrap)
   );

   pa_flag u_ovf (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (wrap),
      .clr   (ovf_clr),
      .ie    (ovf_ie),
      .flag  (ovf_flag),
      .irq   (ovf_irq)
   );

   pa_flag u_edge (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (edge_set),
      .clr   (edge_clr),
      .ie    (edge_ie),
      .flag  (edge_flag),
      .irq   (edge_irq)
   );
endmodule

// File: rtl/pa_checker.sv
module pa_checker #(
   parameter int CNT_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             slow_tick,
   input logic             cfg_en,
   input logic             cfg_gated,
   input logic             cnt_wr,
   input logic [CNT_W-1:0] cnt_wdata,
   input logic             ovf_clr,
   input logic [CNT_W-1:0] cnt_q,
   input logic             ovf_flag,
   input logic             edge_flag
);
   localparam logic [CNT_W-1:0] ALL_ONES = '1;

   AST_LOAD_TAKES_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_wr |=> cnt_q == $past(cnt_wdata)); // R6

   AST_FROZEN_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !cnt_wr) |=> $stable(cnt_q)); // R5

   AST_NO_FLAG_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_en && !edge_flag) |=> !edge_flag); // R5

   AST_GATED_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_gated && !slow_tick && !cnt_wr) |=> $stable(cnt_q)); // R3

   AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_wr |=> (cnt_q == $past(cnt_q)) || (cnt_q == CNT_W'($past(cnt_q) + 1'b1))); // R2

   AST_OVF_ONLY_ON_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ovf_flag) |-> (cnt_q == '0 && $past(cnt_q) == ALL_ONES && !$past(cnt_wr))); // R4

   AST_OVF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ovf_flag && !ovf_clr) |=> ovf_flag); // R8
endmodule

bind pulse_acc_top pa_checker #(.CNT_W(CNT_W)) u_pa_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .slow_tick (slow_tick),
   .cfg_en    (cfg_en),
   .cfg_gated (cfg_gated),
   .cnt_wr    (cnt_wr),
   .cnt_wdata (cnt_wdata),
   .ovf_clr   (ovf_clr),
   .cnt_q     (cnt_q),
   .ovf_flag  (ovf_flag),
   .edge_flag (edge_flag)
);

// File: tb/pulse_acc_top_tb_top.sv
`timescale 1ns/1ps
module pulse_acc_top_tb_top;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pin_in = 1'b0, slow_tick = 1'b0, cfg_en = 1'b0, cfg_gated = 1'b0, cfg_pol = 1'b1;
   logic       cnt_wr = 1'b0, ovf_clr = 1'b0, edge_clr = 1'b0, ovf_ie = 1'b0, edge_ie = 1'b0;
   logic [7:0] cnt_wdata = 8'h00;
   logic [7:0] cnt_q;
   logic       ovf_flag, edge_flag, ovf_irq, edge_irq;

   int n_chk = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   pulse_acc_top dut_i (
      .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .slow_tick(slow_tick),
      .cfg_en(cfg_en), .cfg_gated(cfg_gated), .cfg_pol(cfg_pol),
      .cnt_wr(cnt_wr), .cnt_wdata(cnt_wdata), .ovf_clr(ovf_clr), .edge_clr(edge_clr),
      .ovf_ie(ovf_ie), .edge_ie(edge_ie), .cnt_q(cnt_q), .ovf_flag(ovf_flag),
      .edge_flag(edge_flag), .ovf_irq(ovf_irq), .edge_irq(edge_irq)
   );

   // Behavioural reference: pin history as a queue, counter as an integer
   bit pin_hist[$];
   int m_cnt = 0;
   bit m_ovf = 0, m_edge = 0;
   bit m_seen_prev = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         pin_hist = {};
         m_cnt = 0; m_ovf = 0; m_edge = 0; m_seen_prev = 0;
      end else begin
         bit seen, rise, fall, act, trail, up, eset, oset;
         seen  = (pin_hist.size() >= 2) ? pin_hist[pin_hist.size()-2] : 1'b0;
         rise  = seen && !m_seen_prev;
         fall  = !seen && m_seen_prev;
         act   = cfg_pol ? rise : fall;
         trail = cfg_pol ? fall : rise;
         up    = cfg_en && (cfg_gated ? (slow_tick && (seen == cfg_pol)) : act);
         eset  = cfg_en && (cfg_gated ? trail : act);
         oset  = 0;
         if (cnt_wr) m_cnt = cnt_wdata;
         else if (up) begin
            if (m_cnt == 255) begin m_cnt = 0; oset = 1; end
            else m_cnt = m_cnt + 1;
         end
         if (oset) m_ovf = 1; else if (ovf_clr) m_ovf = 0;
         if (eset) m_edge = 1; else if (edge_clr) m_edge = 0;
         m_seen_prev = seen;
         pin_hist.push_back(pin_in);
         if (pin_hist.size() > 2) void'(pin_hist.pop_front());
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
      end
   endtask

   bit compare_on = 0;
   always @(negedge clk) begin
      if (compare_on && rst_n) begin
         chk(cnt_q == m_cnt[7:0], "R2,R3,R5,R6 model counter", cnt_q, m_cnt);
         chk(ovf_flag == m_ovf, "R4,R8 model ovf_flag", ovf_flag, m_ovf);
         chk(edge_flag == m_edge, "R7,R8 model edge_flag", edge_flag, m_edge);
         chk(ovf_irq == (m_ovf && ovf_ie), "R9 model ovf_irq", ovf_irq, m_ovf && ovf_ie);
         chk(edge_irq == (m_edge && edge_ie), "R9 model edge_irq", edge_irq, m_edge && edge_ie);
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic load(input logic [7:0] v);
      cnt_wr = 1; cnt_wdata = v; step(1); cnt_wr = 0;
   endtask

   task automatic clr_both();
      ovf_clr = 1; edge_clr = 1; step(1); ovf_clr = 0; edge_clr = 0;
   endtask

   task automatic pulse_pin(input int n);
      for (int i = 0; i < n; i++) begin
         pin_in = ~pin_in; step(4); pin_in = ~pin_in; step(4);
      end
   endtask

   initial begin
      #(200000 * 10);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      step(3);
      chk(cnt_q == 0 && !ovf_flag && !edge_flag && !ovf_irq && !edge_irq, "R1 during reset", cnt_q, 0);
      rst_n = 1; step(1);
      chk(cnt_q == 0 && !ovf_flag && !edge_flag, "R1 after reset", cnt_q, 0);
      compare_on = 1;

      // R2 event, rising edges
      cfg_en = 1; cfg_gated = 0; cfg_pol = 1; step(2);
      pulse_pin(5);
      chk(cnt_q == 8'd5, "R2 five rising edges", cnt_q, 5);
      chk(edge_flag == 1, "R7 event edge flag", edge_flag, 1);

      // R10 latency
      load(8'h00); step(1);
      pin_in = 1; step(1);
      chk(cnt_q == 0, "R10 no change after 1 edge", cnt_q, 0);
      step(1);
      chk(cnt_q == 0, "R10 no change after 2 edges", cnt_q, 0);
      step(1);
      chk(cnt_q == 1, "R10 change after 3rd edge", cnt_q, 1);
      pin_in = 0; step(4);
      chk(cnt_q == 1, "R2 fall ignored with pol=1", cnt_q, 1);

      // R2 falling edges
      cfg_pol = 0; load(8'h00); step(1);
      pin_in = 1; step(4);
      chk(cnt_q == 0, "R2 rise ignored with pol=0", cnt_q, 0);
      pin_in = 0; step(4);
      chk(cnt_q == 1, "R2 fall counted with pol=0", cnt_q, 1);

      // R3 gated, high level
      cfg_gated = 1; cfg_pol = 1; load(8'h00); clr_both();
      pin_in = 1; step(4);
      for (int i = 0; i < 6; i++) begin slow_tick = 1; step(1); slow_tick = 0; step(1); end
      chk(edge_flag == 0, "R7 gate leading edge does not set flag", edge_flag, 0);
      pin_in = 0; step(4);
      chk(edge_flag == 1, "R7 gate trailing edge sets flag", edge_flag, 1);
      for (int i = 0; i < 3; i++) begin slow_tick = 1; step(1); slow_tick = 0; step(1); end
      chk(cnt_q == 6, "R3 six ticks while gate open", cnt_q, 6);

      // R4 wrap and R9 irq
      cfg_gated = 0; cfg_pol = 1; load(8'hFE); clr_both(); ovf_ie = 1; edge_ie = 1;
      pulse_pin(2);
      chk(cnt_q == 0, "R4 wrap to zero", cnt_q, 0);
      chk(ovf_flag == 1, "R4 overflow flag set", ovf_flag, 1);
      chk(ovf_irq == 1 && edge_irq == 1, "R9 irqs asserted", {ovf_irq, edge_irq}, 3);
      ovf_ie = 0; edge_ie = 0; step(1);
      chk(ovf_irq == 0 && edge_irq == 0, "R9 irqs masked", {ovf_irq, edge_irq}, 0);

      // R5 enable off
      load(8'h10); clr_both(); cfg_en = 0;
      pulse_pin(3);
      cfg_gated = 1; pin_in = 1; step(4);
      slow_tick = 1; step(3); slow_tick = 0; pin_in = 0; step(4);
      chk(cnt_q == 8'h10, "R5 counter held while disabled", cnt_q, 16);
      chk(edge_flag == 0 && ovf_flag == 0, "R5 no flags while disabled", edge_flag, 0);
      cfg_en = 1;

      // R6 write beats increment
      cfg_gated = 1; cfg_pol = 1; pin_in = 1; step(4);
      cnt_wr = 1; cnt_wdata = 8'h40; slow_tick = 1; step(1);
      cnt_wr = 0; slow_tick = 0;
      chk(cnt_q == 8'h40, "R6 write wins over tick", cnt_q, 64);

      // R8 set beats clear
      load(8'hFF); clr_both();
      slow_tick = 1; ovf_clr = 1; step(1);
      slow_tick = 0; ovf_clr = 0;
      chk(cnt_q == 0 && ovf_flag == 1, "R8 set wins over clear", ovf_flag, 1);
      step(2);
      chk(ovf_flag == 1, "R8 flag sticky", ovf_flag, 1);
      ovf_clr = 1; step(1); ovf_clr = 0;
      chk(ovf_flag == 0, "R8 clear pulse clears", ovf_flag, 0);
      pin_in = 0; step(4);

      // Random mixed phase compared against the model
      for (int c = 0; c < 4000; c++) begin
         if ($urandom % 3 == 0) pin_in = ~pin_in;
         slow_tick = ($urandom % 4 == 0);
         ovf_clr   = ($urandom % 16 == 0);
         edge_clr  = ($urandom % 16 == 0);
         cnt_wr    = ($urandom % 60 == 0);
         cnt_wdata = 8'($urandom);
         cfg_en    = ($urandom % 30 != 0);
         ovf_ie    = ($urandom % 2 == 0);
         edge_ie   = ($urandom % 2 == 0);
         if (c % 400 == 0) begin cfg_gated = $urandom % 2; cfg_pol = $urandom % 2; end
         step(1);
      end

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end
endmodule